// File: doc/BRIEF.md
# SPI Buffer and Interrupt Block

This block is the register-side half of a serial peripheral interface controller. Software reaches it over a simple 32-bit register bus. A word-level shift engine connects on the other side. Two 8-entry, 32-bit queues decouple the two sides. Words written by software queue up for the engine, and words the engine receives queue up for software. Writes and reads at the data address reach different queues: a write goes to the transmit queue and a read comes from the receive queue.

The block has a global enable, programmable fill levels for each queue and a flush strobe for each queue. It also has a receive-not-empty status bit and three sticky event flags: receive overrun, receive level reached and transmit level reached. Reading the interrupt-status address returns these flags together with a live receive-ready indication. Writing ones to the same address clears the flags. A single interrupt line is the OR of the enabled flags. The engine is only offered a transmit word when the receive queue has a free slot, so every word sent has room for its reply.

Register offsets (byte addresses): control 0x00, queue control 0x04, status 0x08, interrupt status/clear 0x0C, interrupt enable 0x10, data 0x14.

Top module: `spi_buf_irq`

## Requirements
- R1: After synchronous reset, the following are all zero or empty: both queues, status, interrupt status, interrupt enable, the enable bit, `irq` and `eng_tx_valid`.
- R2: A write to offset 0x14 appends the word to the transmit queue. The engine receives the words in write order on `eng_tx_data`. Writes made while 8 words are queued are discarded.
- R3: A read strobe at offset 0x14 removes the oldest received word and returns it on `reg_rdata` on the clock after the strobe. A read of an empty queue returns 0 and changes nothing.
- R4: Status (offset 0x08) bit 0 reads 1 exactly when the receive queue holds at least one word.
- R5: Control (offset 0x00) bit 0 enables the block. While it is 0, `eng_tx_valid` stays low.
- R6: `eng_tx_valid` is high only while the transmit queue is non-empty and the receive queue is not full.
- R7: A word presented on `eng_rx_valid` while the receive queue holds 8 words is dropped and sets the overrun flag (interrupt status bit 0).
- R8: Queue-control bits 3:0 hold the receive level. When an accepted receive word brings the count equal to a non-zero level, flag bit 3 is set. Bit 9 reads 1 while the count is at or above a non-zero level.
- R9: At offset 0x0C, writing 1 to bit 0, 3 or 4 clears the overrun, receive-level or transmit-level flag. Writing 0 leaves a flag unchanged.
- R10: Writing 1 to queue-control bit 12 empties the transmit queue, and writing 1 to bit 4 empties the receive queue. Both flush bits read back as 0, while the level fields read back as written.
- R11: Interrupt-enable bit 0 gates the overrun flag and bit 3 gates the receive-level flag. `irq` is high one clock after an enabled flag is set and low one clock after it clears.
- R12: Queue-control bits 11:8 hold the transmit level. When a word leaves the transmit queue and the remaining count equals this level, flag bit 4 is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 6 | Byte address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, registered |
| eng_tx_valid | output | 1 | Transmit word offered to the engine |
| eng_tx_data | output | 32 | Oldest transmit word |
| eng_tx_take | input | 1 | Engine accepts the offered word |
| eng_rx_valid | input | 1 | Engine delivers a received word |
| eng_rx_data | input | 32 | Received word |
| irq | output | 1 | Interrupt request |

## Verification
The bench fills the transmit queue beyond 8 words. A design that wraps a pointer there would replay an old word or lose the oldest one. It overfills the receive queue and checks three things: the ninth word is absent from the read-back, the overrun flag is set, and the engine is no longer offered data. A design missing the room check would let replies be lost. It moves the receive count across its level in both directions, so a level-triggered flag wrongly cleared by a pop, or a ready bit stuck high, would show. It also counts the one-cycle lag of `irq` on both enable and clear.

// File: rtl/spi_buf_pkg.sv
package spi_buf_pkg;
  typedef enum logic [3:0] {
    RI_CTRL = 4'h0,
    RI_QCTL = 4'h1,
    RI_STAT = 4'h2,
    RI_ISC  = 4'h3,
    RI_IEN  = 4'h4,
    RI_DATA = 4'h5
  } reg_idx_e;

  localparam int B_EN        = 0;
  localparam int B_RXLVL_LO  = 0;
  localparam int B_RXFLUSH   = 4;
  localparam int B_TXLVL_LO  = 8;
  localparam int B_TXFLUSH   = 12;
  localparam int B_F_OVR     = 0;
  localparam int B_F_RC      = 3;
  localparam int B_F_TC      = 4;
  localparam int B_F_RDY     = 9;
endpackage

// File: rtl/spi_buf_fifo.sv
module spi_buf_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 8,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             flush,
  input  logic             push,
  input  logic [W-1:0]     wdata,
  input  logic             pop,
  output logic [W-1:0]     rdata,
  output logic [CNT_W-1:0] count,
  output logic             full,
  output logic             empty,
  output logic             push_ok,
  output logic             pop_ok
);
  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wp, rp;

  assign full    = (count == CNT_W'(DEPTH));
  assign empty   = (count == '0);
  assign push_ok = push & ~full;
  assign pop_ok  = pop & ~empty;
  assign rdata   = mem[rp];

  function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (push_ok) mem[wp] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (push_ok) wp <= nxt(wp);
      if (pop_ok)  rp <= nxt(rp);
      count <= count + CNT_W'(push_ok) - CNT_W'(pop_ok);
    end
  end
endmodule

// File: rtl/spi_buf_irq_logic.sv
module spi_buf_irq_logic #(
  parameter int CNT_W = 4,
  parameter int LVL_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rx_drop,
  input  logic             rx_push_ok,
  input  logic [CNT_W-1:0] rx_cnt_next,
  input  logic [CNT_W-1:0] rx_count,
  input  logic [LVL_W-1:0] rx_lvl,
  input  logic             tx_pop_ok,
  input  logic [CNT_W-1:0] tx_cnt_next,
  input  logic [LVL_W-1:0] tx_lvl,
  input  logic             clr_stb,
  input  logic             clr_ovr,
  input  logic             clr_rc,
  input  logic             clr_tc,
  input  logic             ie_ovr,
  input  logic             ie_rc,
  output logic             flag_ovr,
  output logic             flag_rc,
  output logic             flag_tc,
  output logic             rx_ready,
  output logic             irq
);
  logic set_rc, set_tc;

  assign set_rc   = rx_push_ok && (rx_lvl != '0) && (int'(rx_cnt_next) == int'(rx_lvl));
  assign set_tc   = tx_pop_ok && (int'(tx_cnt_next) == int'(tx_lvl));
  assign rx_ready = (rx_lvl != '0) && (int'(rx_count) >= int'(rx_lvl));

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_ovr <= 1'b0;
      flag_rc  <= 1'b0;
      flag_tc  <= 1'b0;
      irq      <= 1'b0;
    end else begin
      if (rx_drop)                flag_ovr <= 1'b1;
      else if (clr_stb && clr_ovr) flag_ovr <= 1'b0;
      if (set_rc)                 flag_rc  <= 1'b1;
      else if (clr_stb && clr_rc)  flag_rc  <= 1'b0;
      if (set_tc)                 flag_tc  <= 1'b1;
      else if (clr_stb && clr_tc)  flag_tc  <= 1'b0;
      irq <= (flag_ovr & ie_ovr) | (flag_rc & ie_rc);
    end
  end
endmodule

// File: rtl/spi_buf_irq.sv
module spi_buf_irq
  import spi_buf_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 6,
  parameter int LVL_W  = 4,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int IDX_W = ADDR_W - 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              eng_tx_valid,
  output logic [DATA_W-1:0] eng_tx_data,
  input  logic              eng_tx_take,
  input  logic              eng_rx_valid,
  input  logic [DATA_W-1:0] eng_rx_data,
  output logic              irq
);
  logic [IDX_W-1:0] idx;
  logic             ctrl_en, ie_ovr, ie_rc;
  logic [LVL_W-1:0] rx_lvl, tx_lvl;
  logic             wr_ctrl, wr_qctl, wr_isc, wr_ien, wr_data, rd_data;
  logic             tx_flush, rx_flush;
  logic [CNT_W-1:0] tx_count, rx_count, tx_cnt_next, rx_cnt_next;
  logic             tx_full, tx_empty, rx_full, rx_empty;
  logic             tx_push_ok, tx_pop_ok, rx_push_ok, rx_pop_ok;
  logic [DATA_W-1:0] rx_head, rd_val;
  logic             flag_ovr, flag_rc, flag_tc, rx_ready;

  assign idx      = reg_addr[ADDR_W-1:2];
  assign wr_ctrl  = reg_wr && (idx == IDX_W'(RI_CTRL));
  assign wr_qctl  = reg_wr && (idx == IDX_W'(RI_QCTL));
  assign wr_isc   = reg_wr && (idx == IDX_W'(RI_ISC));
  assign wr_ien   = reg_wr && (idx == IDX_W'(RI_IEN));
  assign wr_data  = reg_wr && (idx == IDX_W'(RI_DATA));
  assign rd_data  = reg_rd && (idx == IDX_W'(RI_DATA));
  assign tx_flush = wr_qctl && reg_wdata[B_TXFLUSH];
  assign rx_flush = wr_qctl && reg_wdata[B_RXFLUSH];

  assign eng_tx_valid = ctrl_en & ~tx_empty & ~rx_full;

  spi_buf_fifo #(.W(DATA_W), .DEPTH(DEPTH)) i_txq (
    .clk(clk), .rst(rst), .flush(tx_flush),
    .push(wr_data), .wdata(reg_wdata),
    .pop(eng_tx_valid && eng_tx_take), .rdata(eng_tx_data),
    .count(tx_count), .full(tx_full), .empty(tx_empty),
    .push_ok(tx_push_ok), .pop_ok(tx_pop_ok)
  );

  spi_buf_fifo #(.W(DATA_W), .DEPTH(DEPTH)) i_rxq (
    .clk(clk), .rst(rst), .flush(rx_flush),
    .push(eng_rx_valid), .wdata(eng_rx_data),
    .pop(rd_data), .rdata(rx_head),
    .count(rx_count), .full(rx_full), .empty(rx_empty),
    .push_ok(rx_push_ok), .pop_ok(rx_pop_ok)
  );

  assign tx_cnt_next = tx_count + CNT_W'(tx_push_ok) - CNT_W'(tx_pop_ok);
  assign rx_cnt_next = rx_count + CNT_W'(rx_push_ok) - CNT_W'(rx_pop_ok);

  spi_buf_irq_logic #(.CNT_W(CNT_W), .LVL_W(LVL_W)) i_irq (
    .clk(clk), .rst(rst),
    .rx_drop(eng_rx_valid && rx_full), .rx_push_ok(rx_push_ok),
    .rx_cnt_next(rx_cnt_next), .rx_count(rx_count), .rx_lvl(rx_lvl),
    .tx_pop_ok(tx_pop_ok), .tx_cnt_next(tx_cnt_next), .tx_lvl(tx_lvl),
    .clr_stb(wr_isc), .clr_ovr(reg_wdata[B_F_OVR]),
    .clr_rc(reg_wdata[B_F_RC]), .clr_tc(reg_wdata[B_F_TC]),
    .ie_ovr(ie_ovr), .ie_rc(ie_rc),
    .flag_ovr(flag_ovr), .flag_rc(flag_rc), .flag_tc(flag_tc),
    .rx_ready(rx_ready), .irq(irq)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_en <= 1'b0;
      ie_ovr  <= 1'b0;
      ie_rc   <= 1'b0;
      rx_lvl  <= '0;
      tx_lvl  <= '0;
    end else begin
      if (wr_ctrl) ctrl_en <= reg_wdata[B_EN];
      if (wr_qctl) begin
        rx_lvl <= reg_wdata[B_RXLVL_LO +: LVL_W];
        tx_lvl <= reg_wdata[B_TXLVL_LO +: LVL_W];
      end
      if (wr_ien) begin
        ie_ovr <= reg_wdata[B_F_OVR];
        ie_rc  <= reg_wdata[B_F_RC];
      end
    end
  end

  always_comb begin
    rd_val = '0;
    case (idx)
      IDX_W'(RI_CTRL): rd_val[B_EN] = ctrl_en;
      IDX_W'(RI_QCTL): begin
        rd_val[B_RXLVL_LO +: LVL_W] = rx_lvl;
        rd_val[B_TXLVL_LO +: LVL_W] = tx_lvl;
      end
      IDX_W'(RI_STAT): rd_val[0] = ~rx_empty;
      IDX_W'(RI_ISC): begin
        rd_val[B_F_OVR] = flag_ovr;
        rd_val[B_F_RC]  = flag_rc;
        rd_val[B_F_TC]  = flag_tc;
        rd_val[B_F_RDY] = rx_ready;
      end
      IDX_W'(RI_IEN): begin
        rd_val[B_F_OVR] = ie_ovr;
        rd_val[B_F_RC]  = ie_rc;
      end
      IDX_W'(RI_DATA): rd_val = rx_empty ? '0 : rx_head;
      default: rd_val = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)         reg_rdata <= '0;
    else if (reg_rd) reg_rdata <= rd_val;
  end
endmodule

// File: rtl/spi_buf_irq_chk.sv
module spi_buf_irq_chk #(
  parameter int DEPTH = 8,
  parameter int CNT_W = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             ctrl_en,
  input logic             eng_tx_valid,
  input logic             rx_full,
  input logic             eng_rx_valid,
  input logic             flag_ovr,
  input logic             flag_rc,
  input logic             ie_ovr,
  input logic             ie_rc,
  input logic             irq,
  input logic [CNT_W-1:0] rx_count
);
  assert_drop_sets_ovr_R7: assert property (@(posedge clk) disable iff (rst)
    (eng_rx_valid && rx_full) |=> flag_ovr);

  assert_off_no_tx_R5: assert property (@(posedge clk) disable iff (rst)
    !ctrl_en |-> !eng_tx_valid);

  assert_tx_needs_room_R6: assert property (@(posedge clk) disable iff (rst)
    eng_tx_valid |-> !rx_full);

  assert_irq_follows_R11: assert property (@(posedge clk) disable iff (rst)
    ((flag_ovr && ie_ovr) || (flag_rc && ie_rc)) |=> irq);

  assert_rx_bound_R3: assert property (@(posedge clk) disable iff (rst)
    int'(rx_count) <= DEPTH);
endmodule

bind spi_buf_irq spi_buf_irq_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W)) i_chk (
  .clk(clk), .rst(rst), .ctrl_en(ctrl_en), .eng_tx_valid(eng_tx_valid),
  .rx_full(rx_full), .eng_rx_valid(eng_rx_valid), .flag_ovr(flag_ovr),
  .flag_rc(flag_rc), .ie_ovr(ie_ovr), .ie_rc(ie_rc), .irq(irq),
  .rx_count(rx_count)
);

// File: tb/test_spi_buf_irq.sv
module test_spi_buf_irq;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [5:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        eng_tx_valid;
  logic [31:0] eng_tx_data;
  logic        eng_tx_take = 1'b0;
  logic        eng_rx_valid = 1'b0;
  logic [31:0] eng_rx_data = '0;
  logic        irq;

  int n_run = 0, n_fail = 0;
  logic [31:0] v;

  localparam logic [5:0] A_CTRL = 6'h00, A_QCTL = 6'h04, A_STAT = 6'h08,
                         A_ISC = 6'h0C, A_IEN = 6'h10, A_DATA = 6'h14;

  localparam logic [63:0] VEC [6] = '{
    {32'h0000_0001, 32'hFFFF_FFFE},
    {32'hDEAD_BEEF, 32'h1234_5678},
    {32'h8000_0000, 32'h0000_0000},
    {32'h0F0F_0F0F, 32'hF0F0_F0F0},
    {32'h0000_0000, 32'hFFFF_FFFF},
    {32'hCAFE_0042, 32'h0042_CAFE}
  };

  always #4 clk = ~clk;

  spi_buf_irq i_spi_buf_irq (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .eng_tx_valid(eng_tx_valid), .eng_tx_data(eng_tx_data),
    .eng_tx_take(eng_tx_take), .eng_rx_valid(eng_rx_valid),
    .eng_rx_data(eng_rx_data), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk); reg_rd = 1'b1; reg_addr = a;
    @(negedge clk); reg_rd = 1'b0; d = reg_rdata;
  endtask

  task automatic take();
    @(negedge clk); eng_tx_take = 1'b1;
    @(negedge clk); eng_tx_take = 1'b0;
  endtask

  task automatic give(input logic [31:0] d);
    @(negedge clk); eng_rx_valid = 1'b1; eng_rx_data = d;
    @(negedge clk); eng_rx_valid = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1 irq", {31'b0, irq}, 32'h0);
    check("R1 tx_valid", {31'b0, eng_tx_valid}, 32'h0);
    rd(A_STAT, v); check("R1 status", v, 32'h0);
    rd(A_ISC, v);  check("R1 isc", v, 32'h0);
    rd(A_IEN, v);  check("R1 ien", v, 32'h0);
    rd(A_CTRL, v); check("R1 ctrl", v, 32'h0);

    // R5 enable gating
    wr(A_DATA, 32'hA5A5_0001);
    check("R5 disabled", {31'b0, eng_tx_valid}, 32'h0);
    wr(A_CTRL, 32'h1);
    check("R5 enabled", {31'b0, eng_tx_valid}, 32'h1);
    check("R2 head", eng_tx_data, 32'hA5A5_0001);
    wr(A_QCTL, 32'h0000_1000);
    check("R10 tx flush", {31'b0, eng_tx_valid}, 32'h0);

    // table walk: R2 / R3 round trips
    for (int i = 0; i < 6; i++) begin
      wr(A_DATA, VEC[i][63:32]);
      check("R2 table tx", {eng_tx_valid, eng_tx_data[30:0]}, {1'b1, VEC[i][62:32]});
      check("R2 table msb", {31'b0, eng_tx_data[31]}, {31'b0, VEC[i][63]});
      take();
      give(VEC[i][31:0]);
      rd(A_DATA, v); check("R3 table rx", v, VEC[i][31:0]);
    end

    // R2 transmit overfill
    wr(A_CTRL, 32'h0);
    for (int k = 0; k < 10; k++) wr(A_DATA, 32'h100 + k);
    wr(A_CTRL, 32'h1);
    for (int k = 0; k < 8; k++) begin
      check("R2 order", {31'b0, eng_tx_valid}, 32'h1);
      check("R2 order data", eng_tx_data, 32'h100 + k);
      take();
    end
    check("R2 extra dropped", {31'b0, eng_tx_valid}, 32'h0);

    // R7 / R6 / R4 / R3 receive overfill
    for (int k = 0; k < 9; k++) give(32'h200 + k);
    rd(A_ISC, v); check("R7 overrun flag", v & 32'h1, 32'h1);
    rd(A_STAT, v); check("R4 not empty", v, 32'h1);
    wr(A_DATA, 32'h55);
    check("R6 blocked when rx full", {31'b0, eng_tx_valid}, 32'h0);
    for (int k = 0; k < 8; k++) begin
      rd(A_DATA, v); check("R3 rx order", v, 32'h200 + k);
    end
    rd(A_DATA, v); check("R7 ninth dropped", v, 32'h0);
    rd(A_STAT, v); check("R4 empty", v, 32'h0);
    check("R6 room again", {31'b0, eng_tx_valid}, 32'h1);
    wr(A_QCTL, 32'h0000_1000);

    // R9 / R10 / R8 levels
    wr(A_ISC, 32'h19);
    rd(A_ISC, v); check("R9 clear all", v, 32'h0);
    wr(A_QCTL, 32'h0000_0103);
    rd(A_QCTL, v); check("R10 readback", v, 32'h0000_0103);
    give(32'h1); give(32'h2);
    rd(A_ISC, v); check("R8 below level", v, 32'h0);
    give(32'h3);
    rd(A_ISC, v); check("R8 level reached", v, 32'h208);
    rd(A_DATA, v);
    rd(A_ISC, v); check("R8 ready drops, flag sticky", v, 32'h008);
    check("R11 masked", {31'b0, irq}, 32'h0);
    wr(A_IEN, 32'h8);
    check("R11 lag", {31'b0, irq}, 32'h0);
    @(negedge clk);
    check("R11 rc irq", {31'b0, irq}, 32'h1);
    wr(A_ISC, 32'h8);
    @(negedge clk);
    check("R9 R11 cleared", {31'b0, irq}, 32'h0);
    wr(A_QCTL, 32'h0000_0113);
    rd(A_STAT, v); check("R10 rx flush", v, 32'h0);
    rd(A_QCTL, v); check("R10 flush bits read 0", v, 32'h0000_0103);

    // R11 overrun interrupt
    wr(A_IEN, 32'h1);
    for (int k = 0; k < 9; k++) give(32'h400 + k);
    @(negedge clk);
    check("R11 ovr irq", {31'b0, irq}, 32'h1);
    rd(A_ISC, v); check("R7 R8 flags", v, 32'h209);
    wr(A_ISC, 32'h1);
    rd(A_ISC, v); check("R9 ovr only cleared", v, 32'h208);
    check("R11 irq low", {31'b0, irq}, 32'h0);
    wr(A_QCTL, 32'h0000_0113);
    wr(A_ISC, 32'h19);
    wr(A_IEN, 32'h0);

    // R12 transmit level
    wr(A_DATA, 32'h301); wr(A_DATA, 32'h302); wr(A_DATA, 32'h303);
    take();
    rd(A_ISC, v); check("R12 above level", v, 32'h0);
    take();
    rd(A_ISC, v); check("R12 level hit", v, 32'h10);
    wr(A_ISC, 32'h10);
    take();
    rd(A_ISC, v); check("R12 cleared, not reset by drain", v, 32'h0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule